// File: doc/BRIEF.md
# Radiation Upset Monitor Register Chain

This block detects bit flips in ordinary logic flip-flops by pushing a known repeating stream through a long, wide register chain and checking every word that leaves the far end. A generator at the head of the chain produces a 33-word cycle for the default 32-bit width. The cycle starts with a word of all zeros. A single set bit then moves from the top bit down to bit 0, one position per word. A checker at the tail runs its own copy of that cycle, lagging the head by exactly the chain depth. It compares each outgoing word with the word it expects and reports every difference.

Each mismatch produces a one-cycle report that carries the XOR syndrome and the phase index of the expected word. A saturating counter totals the mismatching words. A per-bit classifier separates the two kinds of fault. A flip that hits a bit once and does not come back counts as a transient. A bit that fails in two back-to-back pattern cycles is marked persistent, which points to a corrupted configuration cell, and stays marked until reset. Two emulation inputs let a test corrupt one chosen stage. One inverts selected bits for one shift. The other holds selected bits at zero.

Top module: `seu_chain_monitor`

## Requirements
- R1: The head of the chain receives a repeating cycle of WIDTH+1 words. Phase 0 is all zeros. Phase k (1..WIDTH) has only bit WIDTH-k set. After reset the cycle starts at phase 0.
- R2: The chain advances only on cycles where `shift_en` is high. A word written at the head reaches `tail` after DEPTH enabled shifts, and the tail holds its value while `shift_en` is low.
- R3: `armed` is low after reset and rises once DEPTH enabled shifts have taken place. No mismatch is reported while `armed` is low.
- R4: On each enabled shift with `armed` high, the outgoing word is compared with the expected phase word. On the next cycle, `err_valid` pulses if the two differ. With the pulse, `err_syndrome` carries their XOR and `err_phase` carries the expected phase index (0..WIDTH).
- R5: While `shift_en` is low, no word is compared and `err_valid` stays low, even when a corrupted word sits at the tail.
- R6: `err_count` increases by one for every word reported as mismatching and stops at its all-ones value.
- R7: A bit that mismatches in two consecutive pattern cycles sets its bit in `persistent_mask`. That bit then stays set until reset.
- R8: At the end of each pattern cycle, `transient_count` increases by the number of bits that meet all of these conditions: they mismatched in the previous cycle, did not mismatch in this one, and are not persistent. It saturates at all ones.
- R9: Reset clears the chain, both counters, `persistent_mask`, `armed` and `err_valid`.
- R10: On an enabled shift, stage INJ_STAGE loads the previous stage's word XOR `upset_flip`, with the bits in `upset_stuck` forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_en | input | 1 | Advance chain, generator and checker |
| upset_flip | input | WIDTH | Bits inverted at the injection stage on this shift |
| upset_stuck | input | WIDTH | Bits held at 0 at the injection stage |
| err_valid | output | 1 | One-cycle mismatch report |
| err_syndrome | output | WIDTH | XOR of received and expected word |
| err_phase | output | clog2(WIDTH+1) | Phase index of the expected word |
| err_count | output | CNT_W | Saturating count of mismatching words |
| transient_count | output | CNT_W | Saturating count of one-off bit failures |
| persistent_mask | output | WIDTH | Bits judged persistently faulty |
| armed | output | 1 | Chain filled, comparison active |

## Verification
The bench builds the block with WIDTH=8, DEPTH=12, INJ_STAGE=5 and CNT_W=4. With these values the pattern cycle is 9 words and the chain fills in 12 shifts, so many full cycles, several fault classifications and counter saturation all fit into a short run. Stuck bits across the whole word push the 4-bit mismatch counter past its limit within a few cycles. Gaps in `shift_en` during filling and while a bad word waits at the tail exercise the hold-off paths.

// File: rtl/seu_chain_pkg.sv
`timescale 1ns/1ps
package seu_chain_pkg;

  localparam int unsigned MAX_WIDTH = 64;

  // Expected word for a phase: zero at phase 0, else a single one at bit (w - ph).
  function automatic logic [MAX_WIDTH-1:0] walk_word(input int unsigned ph,
                                                     input int unsigned w);
    logic [MAX_WIDTH-1:0] r;
    r = '0;
    if (ph != 0 && ph <= w) r = 64'd1 << (w - ph);
    return r;
  endfunction

  function automatic int unsigned ones(input logic [MAX_WIDTH-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < MAX_WIDTH; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/seu_walk_gen.sv
`timescale 1ns/1ps
module seu_walk_gen #(
  parameter int WIDTH = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           shift_en,
  output logic [WIDTH-1:0]               word,
  output logic [$clog2(WIDTH+1)-1:0]     phase
);
  import seu_chain_pkg::*;

  localparam int PHW  = $clog2(WIDTH+1);
  localparam int LAST = WIDTH;

  logic phase_wrap;
  assign phase_wrap = (phase == PHW'(LAST));

  always_ff @(posedge clk) begin
    if (!rst_n)        phase <= '0;
    else if (shift_en) phase <= phase_wrap ? '0 : phase + 1'b1;
  end

  assign word = WIDTH'(walk_word(32'(phase), WIDTH));

  // R1: after the last walking position the next head word is all zeros
  a_r1_zero_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && phase_wrap) |=> (word == '0));

  // R1: never more than one bit set in a head word
  a_r1_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(word));

endmodule

// File: rtl/seu_reg_chain.sv
`timescale 1ns/1ps
module seu_reg_chain #(
  parameter int WIDTH     = 32,
  parameter int DEPTH     = 400,
  parameter int INJ_STAGE = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] flip_mask,
  input  logic [WIDTH-1:0] stuck_mask,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [DEPTH];
  logic [WIDTH-1:0] stage_d [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign stage_d[g] = din;
    end else if (g == INJ_STAGE) begin : g_inject
      assign stage_d[g] = (stage_q[g-1] ^ flip_mask) & ~stuck_mask;
    end else begin : g_plain
      assign stage_d[g] = stage_q[g-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)        stage_q[g] <= '0;
      else if (shift_en) stage_q[g] <= stage_d[g];
    end
  end

  assign dout = stage_q[DEPTH-1];

  // R2: the tail does not move while shifting is stopped
  a_r2_tail_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(dout));

endmodule

// File: rtl/seu_end_checker.sv
`timescale 1ns/1ps
module seu_end_checker #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 400,
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       shift_en,
  input  logic [WIDTH-1:0]           tail,
  output logic                       err_valid,
  output logic [WIDTH-1:0]           err_syndrome,
  output logic [$clog2(WIDTH+1)-1:0] err_phase,
  output logic [CNT_W-1:0]           err_count,
  output logic [CNT_W-1:0]           transient_count,
  output logic [WIDTH-1:0]           persistent_mask,
  output logic                       armed
);
  import seu_chain_pkg::*;

  localparam int PHW  = $clog2(WIDTH+1);
  localparam int FW   = $clog2(DEPTH+1);
  localparam int LAST = WIDTH;
  localparam int unsigned MAXV = (32'd1 << CNT_W) - 1;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input int unsigned inc);
    if (inc >= (MAXV - 32'(a))) return CNT_W'(MAXV);
    return a + CNT_W'(inc);
  endfunction

  logic [FW-1:0]    fill_q;
  logic [PHW-1:0]   ref_phase;
  logic [WIDTH-1:0] expect_word, diff;
  logic [WIDTH-1:0] cur_hits, prev_hits;
  logic [WIDTH-1:0] hit_now, cur_acc, new_persist, fade;
  logic             cmp_fire, mism_now, period_end;

  assign armed       = (fill_q == FW'(DEPTH));
  assign expect_word = WIDTH'(walk_word(32'(ref_phase), WIDTH));
  assign diff        = tail ^ expect_word;
  assign cmp_fire    = shift_en && armed;
  assign mism_now    = cmp_fire && (diff != '0);
  assign period_end  = cmp_fire && (ref_phase == PHW'(LAST));
  assign hit_now     = cmp_fire ? diff : '0;
  assign cur_acc     = cur_hits | hit_now;
  assign new_persist = hit_now & prev_hits;
  assign fade        = period_end ? (prev_hits & ~cur_acc & ~persistent_mask) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q    <= '0;
      ref_phase <= '0;
    end else if (shift_en) begin
      if (!armed) fill_q <= fill_q + 1'b1;
      else        ref_phase <= (ref_phase == PHW'(LAST)) ? '0 : ref_phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid    <= 1'b0;
      err_syndrome <= '0;
      err_phase    <= '0;
      err_count    <= '0;
    end else begin
      err_valid <= mism_now;
      if (mism_now) begin
        err_syndrome <= diff;
        err_phase    <= ref_phase;
        err_count    <= sat_add(err_count, 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_hits        <= '0;
      prev_hits       <= '0;
      persistent_mask <= '0;
      transient_count <= '0;
    end else begin
      persistent_mask <= persistent_mask | new_persist;
      if (period_end) begin
        prev_hits       <= cur_acc;
        cur_hits        <= '0;
        transient_count <= sat_add(transient_count, ones(64'(fade)));
      end else begin
        cur_hits <= cur_acc;
      end
    end
  end

  // R3: nothing reported before the chain is filled
  a_r3_quiet_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !err_valid);

  // R3: once armed, stays armed until reset
  a_r3_armed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(armed) |-> armed);

  // R5: stopped shifting never yields a report
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> !err_valid);

  // R6: the mismatch counter only moves together with a report
  a_r6_count_with_report: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count != $past(err_count)) |-> err_valid);

  // R7: persistent bits are never cleared outside reset
  a_r7_mask_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((persistent_mask & $past(persistent_mask)) == $past(persistent_mask)));

endmodule

// File: rtl/seu_chain_monitor.sv
`timescale 1ns/1ps
module seu_chain_monitor #(
  parameter int WIDTH     = 32,
  parameter int DEPTH     = 400,
  parameter int INJ_STAGE = DEPTH / 2,
  parameter int CNT_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       shift_en,
  input  logic [WIDTH-1:0]           upset_flip,
  input  logic [WIDTH-1:0]           upset_stuck,
  output logic                       err_valid,
  output logic [WIDTH-1:0]           err_syndrome,
  output logic [$clog2(WIDTH+1)-1:0] err_phase,
  output logic [CNT_W-1:0]           err_count,
  output logic [CNT_W-1:0]           transient_count,
  output logic [WIDTH-1:0]           persistent_mask,
  output logic                       armed
);

  localparam int PHW = $clog2(WIDTH+1);

  logic [WIDTH-1:0] head_word;
  logic [WIDTH-1:0] tail_word;
  logic [PHW-1:0]   head_phase;

  seu_walk_gen #(.WIDTH(WIDTH)) u_gen (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
    .word(head_word), .phase(head_phase)
  );

  seu_reg_chain #(.WIDTH(WIDTH), .DEPTH(DEPTH), .INJ_STAGE(INJ_STAGE)) u_chain (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
    .din(head_word), .flip_mask(upset_flip), .stuck_mask(upset_stuck),
    .dout(tail_word)
  );

  seu_end_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_check (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .tail(tail_word),
    .err_valid(err_valid), .err_syndrome(err_syndrome), .err_phase(err_phase),
    .err_count(err_count), .transient_count(transient_count),
    .persistent_mask(persistent_mask), .armed(armed)
  );

  // R1: head phase stays inside the cycle
  a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(head_phase) <= WIDTH));

endmodule

// File: tb/seu_chain_monitor_bench.sv
`timescale 1ns/1ps
module seu_chain_monitor_bench;

  localparam int W   = 8;
  localparam int D   = 12;
  localparam int INJ = 5;
  localparam int CW  = 4;
  localparam int PHW = $clog2(W+1);
  localparam int P   = W + 1;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_en = 1'b0;
  logic [W-1:0] upset_flip = '0;
  logic [W-1:0] upset_stuck = '0;
  logic err_valid, armed;
  logic [W-1:0] err_syndrome, persistent_mask;
  logic [PHW-1:0] err_phase;
  logic [CW-1:0] err_count, transient_count;

  always #10 clk = ~clk;

  seu_chain_monitor #(.WIDTH(W), .DEPTH(D), .INJ_STAGE(INJ), .CNT_W(CW)) u_seu_chain_monitor (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
    .upset_flip(upset_flip), .upset_stuck(upset_stuck),
    .err_valid(err_valid), .err_syndrome(err_syndrome), .err_phase(err_phase),
    .err_count(err_count), .transient_count(transient_count),
    .persistent_mask(persistent_mask), .armed(armed)
  );

  int checks = 0;
  int errors = 0;

  // bench model of the stream
  logic [W-1:0] model [D];
  int gph, rph, fill, exp_err;
  logic [PHW+W-1:0] sb_q [$];
  logic [PHW+W-1:0] sb_item;

  function automatic logic [W-1:0] pat(input int ph);
    logic [W-1:0] r;
    r = '0;
    if (ph > 0) r[W-ph] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < D; i++) model[i] = '0;
    gph = 0; rph = 0; fill = 0; exp_err = 0;
    sb_q.delete();
  endtask

  // driver: called at a negedge, predicts the coming edge, pushes expected reports
  task automatic step(input logic en_i, input logic [W-1:0] flip_i,
                      input logic [W-1:0] stuck_i);
    logic [W-1:0] x;
    shift_en = en_i; upset_flip = flip_i; upset_stuck = stuck_i;
    if (en_i) begin
      if (fill == D) begin
        x = model[D-1] ^ pat(rph);
        if (x != '0) begin
          sb_q.push_back({PHW'(rph), x});
          if (exp_err < CMAX) exp_err++;
        end
        rph = (rph + 1) % P;
      end
      for (int i = D-1; i > 0; i--)
        model[i] = (i == INJ) ? ((model[i-1] ^ flip_i) & ~stuck_i) : model[i-1];
      model[0] = pat(gph);
      gph = (gph + 1) % P;
      if (fill < D) fill++;
    end
    @(negedge clk);
    shift_en = 1'b0; upset_flip = '0;
  endtask

  task automatic run(input int n, input logic [W-1:0] stuck_i);
    for (int i = 0; i < n; i++) step(1'b1, '0, stuck_i);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; shift_en = 1'b0; upset_flip = '0; upset_stuck = '0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: samples 2 ns after each rising edge, pops the scoreboard
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (err_valid) begin
        checks++;
        if (sb_q.size() == 0) begin
          errors++;
          $display("FAIL R4 R5 unexpected report: actual syn %0h expected none", err_syndrome);
        end else begin
          sb_item = sb_q.pop_front();
          if ({err_phase, err_syndrome} !== sb_item) begin
            errors++;
            $display("FAIL R4 report phase/syndrome: actual %0h/%0h expected %0h/%0h",
                     err_phase, err_syndrome, sb_item[PHW+W-1:W], sb_item[W-1:0]);
          end
        end
      end else if (sb_q.size() != 0) begin
        checks++; errors++;
        sb_item = sb_q.pop_front();
        $display("FAIL R4 missing report: actual none expected syn %0h", sb_item[W-1:0]);
      end
    end
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt_before;
    model_clear();
    @(negedge clk);
    do_reset();
    // R9 reset state
    chk("R9", "err_valid", 32'(err_valid), 0);
    chk("R9", "err_count", 32'(err_count), 0);
    chk("R9", "transient_count", 32'(transient_count), 0);
    chk("R9", "persistent_mask", 32'(persistent_mask), 0);
    chk("R9", "armed", 32'(armed), 0);

    // R3 fill with a gap: armed only after D enabled shifts
    run(4, '0);
    step(1'b0, '0, '0);
    run(D - 5, '0);
    chk("R3", "armed before fill", 32'(armed), 0);
    run(1, '0);
    chk("R3", "armed after fill", 32'(armed), 1);

    // R1 R2 clean stream gives no mismatch over several cycles
    run(4 * P, '0);
    chk("R1", "clean err_count", 32'(err_count), 0);

    // R10 R4 R8 single transient flip
    step(1'b1, 8'h08, '0);
    run(D + 3 * P, '0);
    chk("R6", "err_count after flip", 32'(err_count), 32'(exp_err));
    chk("R8", "transient after flip", 32'(transient_count), 1);
    chk("R7", "no persistent after flip", 32'(persistent_mask), 0);

    // R5 hold a corrupted word at the tail with shifting stopped
    step(1'b1, 8'h02, '0);
    for (int i = 0; i < 3 * D; i++) begin
      if (model[D-1] != pat(rph)) break;
      step(1'b1, '0, '0);
    end
    cnt_before = int'(err_count);
    for (int i = 0; i < 8; i++) step(1'b0, '0, '0);
    chk("R5", "count frozen while idle", 32'(err_count), 32'(cnt_before));
    chk("R5", "no report while idle", 32'(err_valid), 0);
    for (int i = 0; i < 2 * D + 3 * P; i++) step(i % 3 != 0, '0, '0);
    chk("R6", "count after idle window", 32'(err_count), 32'(exp_err));
    chk("R8", "transients after second flip", 32'(transient_count), 2);

    // R10 R8 two bits in one word
    step(1'b1, 8'h21, '0);
    run(D + 3 * P, '0);
    chk("R8", "two-bit transient", 32'(transient_count), 4);

    // R7 stuck bit 6 becomes persistent and stays after release
    run(D + 3 * P, 8'h40);
    run(D + 2 * P, '0);
    chk("R7", "persistent bit 6", 32'(persistent_mask), 32'h40);
    chk("R8", "stuck bit not transient", 32'(transient_count), 4);
    chk("R6", "count after stuck", 32'(err_count), 32'(exp_err));

    // R6 saturation with every bit stuck
    run(D + 4 * P, 8'hFF);
    run(D + 2 * P, '0);
    chk("R6", "saturated count", 32'(err_count), CMAX);
    chk("R7", "all bits persistent", 32'(persistent_mask), 32'hFF);

    // R9 reset again clears everything
    do_reset();
    @(negedge clk);
    chk("R9", "count cleared", 32'(err_count), 0);
    chk("R9", "mask cleared", 32'(persistent_mask), 0);
    chk("R9", "armed cleared", 32'(armed), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule